// File: doc/BRIEF.md
# Automatic Descriptor Poll Timer

This block produces the poll-demand pulses that tell a transmit DMA engine and a receive DMA engine to fetch their descriptor rings again. It has two channels, one for transmit and one for receive, which run independently. Each channel owns a timeout count `n` and a cycle-length select. A channel with a nonzero `n` emits a one-clock poll pulse every `n` poll cycles. A poll cycle lasts either `NORM_BITS` bit times (512 by default) or `LONG_BITS` bit times (8192 by default). At 100 Mbps these are 5.12 us and 81.92 us; at 10 Mbps they are 51.2 us and 819.2 us. A channel with `n = 0` never polls on its own.

Bit times come from `bit_tick`, a strobe that runs at the 100 Mbps bit rate. When `speed_100` is low, only every `SLOW_DIV`-th strobe (10 by default) counts as a bit time, so the same cycle counts cover ten times the wall time. Software can also ask for a poll at any moment through `tx_poll_req` or `rx_poll_req`. Such a request makes a pulse on the next clock and restarts that channel's timer. Writing the 13-bit control word through `cfg_we` restarts both timers one clock later and produces no pulse.

Each channel is a small state machine with three states:
- CH_OFF: automatic polling is disabled.
- CH_RUN: the channel counts bit times and poll cycles.
- CH_FIRE: the poll output is high.

The transitions are as follows:
- Every state moves to CH_FIRE on a software request.
- Every state moves to CH_OFF or CH_RUN on a reload, chosen by whether `n` is zero.
- CH_RUN moves to CH_FIRE when the period expires.
- CH_FIRE moves back to CH_RUN or CH_OFF, chosen by whether `n` is zero.
- CH_OFF stays where it is otherwise.

Top module: `desc_poll_timer`

## Requirements
- R1: The control word is decoded as follows: bit 12 selects the long cycle for TX, bits 11:8 hold the TX timeout, bit 4 selects the long cycle for RX, and bits 3:0 hold the RX timeout. Bits 7:5 have no effect.
- R2: After reset, the TX timeout is 0 and the RX timeout is 1 with the normal cycle. Neither poll output is high while reset is asserted.
- R3: With a timeout `n` other than 0, a channel pulses exactly once every `n` x L bit times. L is `NORM_BITS` when the channel's long select is 0 and `LONG_BITS` when it is 1. A bit time counted in the cycle of a pulse belongs to the next period.
- R4: With `speed_100` = 1, every `bit_tick` is one bit time. With `speed_100` = 0, only every `SLOW_DIV`-th `bit_tick` is a bit time, and the divider starts again from zero each time `speed_100` is 1.
- R5: A channel whose timeout is 0 produces no pulse except in answer to a software request.
- R6: A software request on a channel drives that channel's poll output high in the next clock cycle. It then restarts the channel's period from zero.
- R7: A control-word write restarts both channels' periods on the clock after the write. It produces no pulse of its own, and the new fields govern from that point on.
- R8: A poll pulse lasts one clock cycle unless a further software request arrives in the cycle of the pulse.
- R9: A request, period or expiry on one channel never changes the other channel's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_100 | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps bit-time rate |
| bit_tick | input | 1 | Strobe at the 100 Mbps bit rate |
| cfg_we | input | 1 | Control-word write strobe |
| cfg_wdata | input | 13 | Control word written when `cfg_we` is high |
| tx_poll_req | input | 1 | Software poll request, transmit channel |
| rx_poll_req | input | 1 | Software poll request, receive channel |
| tx_poll | output | 1 | Poll pulse to the transmit DMA engine |
| rx_poll | output | 1 | Poll pulse to the receive DMA engine |

## Verification
The bench targets the exact pulse spacing. It checks that the tick seen in the pulse cycle is carried into the next period: a design that drops it drifts by one bit time per period, and one that counts it twice fires early. It checks that the divider stays in phase at 10 Mbps, that a timeout of 0 stays silent while requests still get through, and that a stream of writes closer together than one period keeps the timers from ever firing. A design that reloaded from the old word, or pulsed on a write, would show up there. The bench also applies back-to-back requests, simultaneous requests on both channels, and a request while the other channel is about to expire, to catch stretched pulses and crosstalk between the channels. Irregular tick patterns combined with speed changes run against the behavioural model on every clock.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_RUN  = 2'd1,
        CH_FIRE = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic       long_cyc;
        logic [3:0] tmo;
    } chan_cfg_t;

    localparam int CW_W        = 13;
    localparam int TMO_W       = 4;
    localparam int NUM_CH      = 2;
    localparam int TX_LONG_BIT = 12;
    localparam int TX_TMO_LSB  = 8;
    localparam int RX_LONG_BIT = 4;
    localparam int RX_TMO_LSB  = 0;

    // Pull one channel's fields out of the control word (channel 0 = TX).
    function automatic chan_cfg_t pick_fields(input logic [CW_W-1:0] cw, input int ch);
        chan_cfg_t f;
        if (ch == 0) begin
            f.long_cyc = cw[TX_LONG_BIT];
            f.tmo      = cw[TX_TMO_LSB +: TMO_W];
        end else begin
            f.long_cyc = cw[RX_LONG_BIT];
            f.tmo      = cw[RX_TMO_LSB +: TMO_W];
        end
        return f;
    endfunction

endpackage

// File: rtl/dpt_prescale.sv
module dpt_prescale #(
    parameter int SLOW_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic speed_100,
    input  logic bit_tick,
    output logic base_tick
);
    localparam int DW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(SLOW_DIV - 1);

    logic [DW-1:0] div_q;

    // R4: the divider only runs in 10 Mbps mode and restarts whenever 100 Mbps is selected
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (speed_100) begin
            div_q <= '0;
        end else if (bit_tick) begin
            div_q <= (div_q == DIV_LAST) ? '0 : div_q + 1'b1;
        end
    end

    always_comb begin
        if (speed_100) begin
            base_tick = bit_tick;
        end else begin
            base_tick = bit_tick && (div_q == DIV_LAST);
        end
    end

endmodule

// File: rtl/dpt_cfg_reg.sv
module dpt_cfg_reg
    import dpt_pkg::*;
#(
    parameter logic [CW_W-1:0] RST_CW = 13'h0001
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CW_W-1:0] cfg_wdata,
    output chan_cfg_t       tx_cfg_o,
    output chan_cfg_t       rx_cfg_o,
    output logic            reload_o
);
    localparam chan_cfg_t TX_RST = pick_fields(RST_CW, 0);
    localparam chan_cfg_t RX_RST = pick_fields(RST_CW, 1);

    chan_cfg_t tx_q;
    chan_cfg_t rx_q;
    logic      reload_q;

    // R1: bits 7:5 carry nothing
    logic unused_gap_bits;
    assign unused_gap_bits = ^cfg_wdata[7:5];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q     <= TX_RST;
            rx_q     <= RX_RST;
            reload_q <= 1'b0;
        end else begin
            reload_q <= cfg_we;
            if (cfg_we) begin
                tx_q <= pick_fields(cfg_wdata, 0);
                rx_q <= pick_fields(cfg_wdata, 1);
            end
        end
    end

    assign tx_cfg_o = tx_q;
    assign rx_cfg_o = rx_q;
    assign reload_o = reload_q;

endmodule

// File: rtl/dpt_channel.sv
module dpt_channel
    import dpt_pkg::*;
#(
    parameter int NORM_BITS = 512,
    parameter int LONG_BITS = 8192,
    parameter bit RST_ON    = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      base_tick,
    input  chan_cfg_t cfg,
    input  logic      reload,
    input  logic      sw_req,
    output logic      poll_o
);
    localparam int BW = $clog2(LONG_BITS);
    localparam logic [BW-1:0] NORM_LAST = BW'(NORM_BITS - 1);
    localparam logic [BW-1:0] LONG_LAST = BW'(LONG_BITS - 1);
    localparam ch_state_e RST_STATE = RST_ON ? CH_RUN : CH_OFF;

    ch_state_e        state_q;
    ch_state_e        state_d;
    logic [BW-1:0]    bit_q;
    logic [BW-1:0]    bit_d;
    logic [TMO_W-1:0] cyc_q;
    logic [TMO_W-1:0] cyc_d;
    logic [BW-1:0]    bit_last;
    logic             end_of_cycle;
    logic             end_of_period;
    logic             tmo_zero;

    assign tmo_zero      = (cfg.tmo == '0);
    assign bit_last      = cfg.long_cyc ? LONG_LAST : NORM_LAST;
    assign end_of_cycle  = (bit_q == bit_last);
    assign end_of_period = end_of_cycle && (cyc_q == cfg.tmo - 1'b1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RST_STATE;
            bit_q   <= '0;
            cyc_q   <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            cyc_q   <= cyc_d;
        end
    end

    // Next state: request beats reload, reload beats counting
    always_comb begin
        state_d = state_q;
        if (sw_req) begin
            state_d = CH_FIRE;
        end else if (reload) begin
            state_d = tmo_zero ? CH_OFF : CH_RUN;
        end else begin
            unique case (state_q)
                CH_OFF:  state_d = CH_OFF;
                CH_RUN:  state_d = (base_tick && end_of_period) ? CH_FIRE : CH_RUN;
                CH_FIRE: state_d = tmo_zero ? CH_OFF : CH_RUN;
                default: state_d = CH_OFF;
            endcase
        end
    end

    // Bit-time and cycle counters
    always_comb begin
        bit_d = bit_q;
        cyc_d = cyc_q;
        if (sw_req || reload) begin
            bit_d = '0;
            cyc_d = '0;
        end else begin
            unique case (state_q)
                CH_OFF: begin
                    bit_d = '0;
                    cyc_d = '0;
                end
                CH_RUN: begin
                    if (base_tick) begin
                        if (end_of_cycle) begin
                            bit_d = '0;
                            cyc_d = end_of_period ? '0 : cyc_q + 1'b1;
                        end else begin
                            bit_d = bit_q + 1'b1;
                        end
                    end
                end
                CH_FIRE: begin
                    // a tick in the pulse cycle opens the next period
                    bit_d = base_tick ? BW'(1) : '0;
                    cyc_d = '0;
                end
                default: begin
                    bit_d = '0;
                    cyc_d = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            CH_FIRE: poll_o = 1'b1;
            default: poll_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/desc_poll_timer.sv
module desc_poll_timer
    import dpt_pkg::*;
#(
    parameter int               NORM_BITS = 512,
    parameter int               LONG_BITS = 8192,
    parameter int               SLOW_DIV  = 10,
    parameter logic [CW_W-1:0]  RST_CW    = 13'h0001
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            speed_100,
    input  logic            bit_tick,
    input  logic            cfg_we,
    input  logic [CW_W-1:0] cfg_wdata,
    input  logic            tx_poll_req,
    input  logic            rx_poll_req,
    output logic            tx_poll,
    output logic            rx_poll
);
    logic                base_tick;
    logic                cfg_reload;
    chan_cfg_t           tx_cfg;
    chan_cfg_t           rx_cfg;
    chan_cfg_t           ch_cfg [NUM_CH];
    logic [NUM_CH-1:0]   ch_req;
    logic [NUM_CH-1:0]   ch_poll;

    dpt_prescale #(
        .SLOW_DIV (SLOW_DIV)
    ) u_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .speed_100 (speed_100),
        .bit_tick  (bit_tick),
        .base_tick (base_tick)
    );

    dpt_cfg_reg #(
        .RST_CW (RST_CW)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .tx_cfg_o  (tx_cfg),
        .rx_cfg_o  (rx_cfg),
        .reload_o  (cfg_reload)
    );

    assign ch_cfg[0] = tx_cfg;
    assign ch_cfg[1] = rx_cfg;
    assign ch_req    = {rx_poll_req, tx_poll_req};

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam chan_cfg_t RST_F = pick_fields(RST_CW, g);
        dpt_channel #(
            .NORM_BITS (NORM_BITS),
            .LONG_BITS (LONG_BITS),
            .RST_ON    (RST_F.tmo != '0)
        ) u_channel (
            .clk       (clk),
            .rst_n     (rst_n),
            .base_tick (base_tick),
            .cfg       (ch_cfg[g]),
            .reload    (cfg_reload),
            .sw_req    (ch_req[g]),
            .poll_o    (ch_poll[g])
        );
    end

    assign tx_poll = ch_poll[0];
    assign rx_poll = ch_poll[1];

endmodule

// File: rtl/desc_poll_timer_chk.sv
module desc_poll_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_poll_req,
    input logic       rx_poll_req,
    input logic       tx_poll,
    input logic       rx_poll,
    input logic [3:0] tx_tmo,
    input logic [3:0] rx_tmo,
    input logic       cfg_reload
);
    // R2
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r2_reset_quiet: assert (!tx_poll && !rx_poll)
                else $error("poll output high during reset");
        end
    end

    // R6
    a_r6_tx_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_poll_req |=> tx_poll);
    a_r6_rx_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_poll_req |=> rx_poll);

    // R5
    a_r5_tx_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_poll_req && tx_tmo == 4'd0 && !tx_poll) |=> !tx_poll);
    a_r5_rx_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_poll_req && rx_tmo == 4'd0 && !rx_poll) |=> !rx_poll);

    // R8
    a_r8_tx_single: assert property (@(posedge clk) disable iff (!rst_n)
        tx_poll |=> (!tx_poll || $past(tx_poll_req)));
    a_r8_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_poll |=> (!rx_poll || $past(rx_poll_req)));

    // R7
    a_r7_tx_reload_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_reload && !tx_poll_req) |=> !tx_poll);
    a_r7_rx_reload_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_reload && !rx_poll_req) |=> !rx_poll);

endmodule

bind desc_poll_timer desc_poll_timer_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_poll_req (tx_poll_req),
    .rx_poll_req (rx_poll_req),
    .tx_poll     (tx_poll),
    .rx_poll     (rx_poll),
    .tx_tmo      (tx_cfg.tmo),
    .rx_tmo      (rx_cfg.tmo),
    .cfg_reload  (cfg_reload)
);

// File: tb/desc_poll_timer_bench.sv
module desc_poll_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 8;
    localparam int LB = 32;
    localparam int SD = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        speed_100 = 1'b1;
    logic        bit_tick = 1'b1;
    logic        cfg_we = 1'b0;
    logic [12:0] cfg_wdata = '0;
    logic        tx_poll_req = 1'b0;
    logic        rx_poll_req = 1'b0;
    logic        tx_poll;
    logic        rx_poll;

    int    checks = 0;
    int    fails = 0;
    bit    done = 1'b0;
    string phase = "R2 reset";
    int    tick_mode = 0;
    logic [15:0] lfsr = 16'hACE1;

    desc_poll_timer #(
        .NORM_BITS (NB),
        .LONG_BITS (LB),
        .SLOW_DIV  (SD)
    ) u_desc_poll_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .speed_100   (speed_100),
        .bit_tick    (bit_tick),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .tx_poll_req (tx_poll_req),
        .rx_poll_req (rx_poll_req),
        .tx_poll     (tx_poll),
        .rx_poll     (rx_poll)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    int m_tmo [2];
    bit m_long [2];
    bit m_on [2];
    bit m_fire [2];
    int m_cnt [2];
    bit m_upd;
    int m_div;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tmo[0] = 0; m_long[0] = 0; m_on[0] = 0;
            m_tmo[1] = 1; m_long[1] = 0; m_on[1] = 1;
            for (int c = 0; c < 2; c++) begin
                m_fire[c] = 0;
                m_cnt[c] = 0;
            end
            m_upd = 0;
            m_div = 0;
        end else begin
            bit base;
            bit req [2];
            req[0] = tx_poll_req;
            req[1] = rx_poll_req;
            base = speed_100 ? bit_tick : (bit_tick && m_div == SD - 1);
            for (int c = 0; c < 2; c++) begin
                int len;
                len = m_long[c] ? LB : NB;
                if (req[c]) begin
                    m_fire[c] = 1; m_cnt[c] = 0;
                end else if (m_upd) begin
                    m_fire[c] = 0; m_on[c] = (m_tmo[c] != 0); m_cnt[c] = 0;
                end else if (m_fire[c]) begin
                    m_fire[c] = 0; m_on[c] = (m_tmo[c] != 0); m_cnt[c] = base ? 1 : 0;
                end else if (m_on[c] && base) begin
                    m_cnt[c]++;
                    if (m_cnt[c] == m_tmo[c] * len) begin
                        m_fire[c] = 1; m_cnt[c] = 0;
                    end
                end
            end
            if (cfg_we) begin
                m_tmo[0]  = int'(cfg_wdata[11:8]);
                m_long[0] = cfg_wdata[12];
                m_tmo[1]  = int'(cfg_wdata[3:0]);
                m_long[1] = cfg_wdata[4];
            end
            m_upd = cfg_we;
            if (speed_100) m_div = 0;
            else if (bit_tick) m_div = (m_div == SD - 1) ? 0 : m_div + 1;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, exp);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({phase, " tx"}, tx_poll, m_fire[0]);
            check({phase, " rx"}, rx_poll, m_fire[1]);
        end
    end

    // bit_tick pattern source
    initial forever begin
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (tick_mode)
            0: bit_tick = 1'b1;
            1: bit_tick = lfsr[0];
            default: bit_tick = ~bit_tick;
        endcase
    end

    task automatic cfg_write(input logic [12:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_count(input int n, output int tc, output int rc);
        tc = 0;
        rc = 0;
        repeat (n) begin
            @(negedge clk);
            #1;
            if (tx_poll) tc++;
            if (rx_poll) rc++;
        end
    endtask

    task automatic req_pulse(input bit tx, input bit rx, input int len);
        @(negedge clk);
        tx_poll_req = tx;
        rx_poll_req = rx;
        repeat (len - 1) @(negedge clk);
        @(negedge clk);
        tx_poll_req = 1'b0;
        rx_poll_req = 1'b0;
    endtask

    initial begin
        int tc;
        int rc;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R2: defaults give RX every NB cycles, TX silent
        phase = "R2 reset defaults";
        run_count(96, tc, rc);
        check_int("R2 tx pulses after reset", tc, 0);
        check_int("R2 rx pulses after reset", rc, 12);

        // R3: TX long n=2, RX normal n=3
        phase = "R3 period";
        cfg_write(13'h1203);
        run_count(300, tc, rc);
        check_int("R3 rx pulses in 300 cycles", rc, 12);

        // R1: stray bits 7:5 set, TX off, RX n=2
        phase = "R1 field decode";
        cfg_write(13'h00E2);
        run_count(160, tc, rc);
        check_int("R1 tx silent with timeout field 0", tc, 0);

        // R4: 10 Mbps, RX n=1 normal => period NB*SD
        phase = "R4 slow speed";
        speed_100 = 1'b0;
        cfg_write(13'h0001);
        do begin @(negedge clk); #1; end while (!rx_poll);
        run_count(96, tc, rc);
        check_int("R4 rx pulses at 10 Mbps", rc, 4);
        cfg_write(13'h1101);
        run_count(400, tc, rc);
        speed_100 = 1'b1;

        // R6 and R9: requests at varied points
        phase = "R6 sw poll";
        cfg_write(13'h0302);
        repeat (5) @(negedge clk);
        req_pulse(1, 0, 1);
        repeat (7) @(negedge clk);
        req_pulse(0, 1, 2);
        repeat (3) @(negedge clk);
        req_pulse(1, 1, 1);
        phase = "R9 independence";
        for (int k = 0; k < 6; k++) begin
            repeat (k + 3) @(negedge clk);
            req_pulse(1, 0, 1);
        end
        repeat (40) @(negedge clk);

        // R5: both off, requests still answered
        phase = "R5 zero off";
        cfg_write(13'h0000);
        run_count(150, tc, rc);
        check_int("R5 tx auto pulses with timeout 0", tc, 0);
        check_int("R5 rx auto pulses with timeout 0", rc, 0);
        req_pulse(1, 0, 1);
        #1;
        check("R5 tx request answered while off", tx_poll, 1'b1);
        repeat (30) @(negedge clk);

        // R7: writes closer than one period keep both timers quiet
        phase = "R7 reload";
        tc = 0;
        rc = 0;
        for (int k = 0; k < 12; k++) begin
            cfg_write(13'h0101);
            repeat (3) begin
                @(negedge clk); #1;
                if (tx_poll) tc++;
                if (rx_poll) rc++;
            end
        end
        check_int("R7 tx pulses under frequent writes", tc, 0);
        check_int("R7 rx pulses under frequent writes", rc, 0);
        run_count(60, tc, rc);

        // R8: irregular ticks and speed changes
        phase = "R8 irregular ticks";
        tick_mode = 1;
        cfg_write(13'h1102);
        run_count(500, tc, rc);
        speed_100 = 1'b0;
        run_count(500, tc, rc);
        tick_mode = 2;
        req_pulse(1, 1, 3);
        run_count(400, tc, rc);
        speed_100 = 1'b1;
        run_count(200, tc, rc);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog (R1 to R9 unfinished): actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule